// File: doc/BRIEF.md
# Gate-Drive Carrier Chopper

This block prepares two PWM channel signals for gate drivers coupled through pulse transformers, which cannot pass a long steady high level. Whenever a channel's PWM input rises, the matching output first delivers a single wide pulse. The width of that pulse is programmable, so the transformer's magnetising current can build up enough to switch the power device reliably. For the rest of the high phase, the output carries a high-frequency carrier whose period and high-time fraction are both programmable. While the PWM input is low, the output stays low.

One carrier generator serves both channels and runs freely from reset. Each channel has its own one-shot timer and its own output register. With chopping disabled, the block acts as a plain one-cycle register stage for both channels. All outputs are registered, so each output lags its PWM input by exactly one clock in every mode.

Top module: `pwm_chopper`

## Requirements
- R1: With `chop_en` low, each output equals its PWM input delayed by one clock cycle.
- R2: With `chop_en` high, an output is low in every cycle that follows a cycle in which its PWM input was low.
- R3: With `chop_en` high, a rising PWM input (low in the previous cycle, or the first cycle after reset, and high now) makes the output high for 8 × (`os_width` + 1) consecutive cycles, starting one cycle later, as long as the input stays high.
- R4: The carrier phase counter k starts at 0 in the first cycle after reset and counts up by one each cycle. The carrier period is 8 × (`car_freq` + 1) cycles. Within a period, eighth number e = floor(k / (`car_freq` + 1)) mod 8.
- R5: For `car_duty` codes 0 to 6, the carrier is high in eighths e ≤ `car_duty`, which gives a high time of (code + 1)/8.
- R6: `car_duty` code 7 behaves as code 3 (50 % duty).
- R7: A low PWM input ends any one-shot pulse in progress at once. The next rising edge starts a new one-shot of full width.
- R8: Each channel's one-shot follows only its own PWM input. Both channels share the same carrier phase.
- R9: While reset is held, both outputs are low.

Output rule with chopping enabled: out(t+1) = pwm(t) AND (shot(t) OR carrier(t)).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| chop_en | input | 1 | 1 = chop outputs, 0 = bypass (registered pass-through) |
| car_freq | input | 3 | Carrier divider: period 8 × (code + 1) clocks |
| car_duty | input | 3 | Carrier high time in eighths: code + 1; code 7 gives half |
| os_width | input | 4 | One-shot width: 8 × (code + 1) clocks |
| pwm_a | input | 1 | PWM input, channel A |
| pwm_b | input | 1 | PWM input, channel B |
| out_a | output | 1 | Chopped output, channel A |
| out_b | output | 1 | Chopped output, channel B |

## Verification
The assertions check four rules on every cycle. An output stays low after a low input. Bypass mode is a one-cycle pass-through. A rising input with chopping enabled raises the output on the next cycle. A low input clears the internal one-shot pulse by the next cycle. The exact one-shot length, the carrier period and duty for each code, the substitution for the reserved duty code, and the independence of the channels are shown only by the bench's scenarios. For those, a cycle-by-cycle reference model built from the requirements predicts every output bit.

// File: rtl/chop_pkg.sv
package chop_pkg;

    localparam int FREQ_W   = 3;
    localparam int DUTY_W   = 3;
    localparam int WIDTH_W  = 4;
    localparam int BASE_DIV = 8;
    localparam int BASE_SH  = $clog2(BASE_DIV);
    localparam int CNT_W    = WIDTH_W + BASE_SH;
    localparam int STEPS    = 1 << DUTY_W;
    localparam int CHANNELS = 2;

    typedef logic [FREQ_W-1:0]  freq_t;
    typedef logic [DUTY_W-1:0]  duty_t;
    typedef logic [WIDTH_W-1:0] width_t;
    typedef logic [CNT_W-1:0]   cnt_t;

    typedef struct packed {
        logic   enable;
        freq_t  freq;
        duty_t  duty;
        width_t width;
    } chop_cfg_t;

    typedef struct packed {
        logic prev;
        cnt_t remain;
    } shot_state_t;

    // Reserved all-ones duty code maps to half duty.
    function automatic duty_t eff_duty(duty_t d);
        return (d == duty_t'(STEPS - 1)) ? duty_t'(STEPS / 2 - 1) : d;
    endfunction

    // Remaining count loaded on a rising edge: BASE_DIV*(w+1)-1.
    function automatic cnt_t shot_len(width_t w);
        return {w, {BASE_SH{1'b1}}};
    endfunction

endpackage

// File: rtl/chop_carrier.sv
module chop_carrier
    import chop_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  freq_t freq,
    input  duty_t duty,
    output logic  carrier
);

    freq_t slot;
    duty_t step;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot <= '0;
            step <= '0;
        end else if (slot >= freq) begin
            slot <= '0;
            step <= step + 1'b1;
        end else begin
            slot <= slot + 1'b1;
        end
    end

    assign carrier = (step <= eff_duty(duty));

endmodule

// File: rtl/chop_oneshot.sv
module chop_oneshot
    import chop_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   pwm,
    input  width_t width,
    output logic   pulse
);

    shot_state_t st;
    logic        rise;

    assign rise  = pwm & ~st.prev;
    assign pulse = rise | (st.remain != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            st.prev <= pwm;
            if (!pwm)
                st.remain <= '0;
            else if (rise)
                st.remain <= shot_len(width);
            else if (st.remain != '0)
                st.remain <= st.remain - 1'b1;
        end
    end

endmodule

// File: rtl/pwm_chopper.sv
module pwm_chopper
    import chop_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       chop_en,
    input  logic [2:0] car_freq,
    input  logic [2:0] car_duty,
    input  logic [3:0] os_width,
    input  logic       pwm_a,
    input  logic       pwm_b,
    output logic       out_a,
    output logic       out_b
);

    chop_cfg_t           cfg;
    logic [CHANNELS-1:0] pwm_in;
    logic [CHANNELS-1:0] shot;
    logic [CHANNELS-1:0] out_q;
    logic                carrier;

    assign cfg    = '{enable: chop_en, freq: car_freq, duty: car_duty, width: os_width};
    assign pwm_in = {pwm_b, pwm_a};

    chop_carrier u_carrier (
        .clk     (clk),
        .rst     (rst),
        .freq    (cfg.freq),
        .duty    (cfg.duty),
        .carrier (carrier)
    );

    for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_chan
        logic q;

        chop_oneshot u_shot (
            .clk   (clk),
            .rst   (rst),
            .pwm   (pwm_in[ch]),
            .width (cfg.width),
            .pulse (shot[ch])
        );

        always_ff @(posedge clk) begin
            if (rst)
                q <= 1'b0;
            else if (cfg.enable)
                q <= pwm_in[ch] & (shot[ch] | carrier);
            else
                q <= pwm_in[ch];
        end

        assign out_q[ch] = q;
    end

    assign out_a = out_q[0];
    assign out_b = out_q[1];

endmodule

// File: rtl/pwm_chopper_chk.sv
module pwm_chopper_chk (
    input logic clk,
    input logic rst,
    input logic chop_en,
    input logic pwm_a,
    input logic pwm_b,
    input logic out_a,
    input logic out_b,
    input logic os_a,
    input logic os_b
);

    a_r2_low_a: assert property (@(posedge clk) disable iff (rst)
        !pwm_a |=> !out_a);
    a_r2_low_b: assert property (@(posedge clk) disable iff (rst)
        !pwm_b |=> !out_b);

    a_r1_bypass_a: assert property (@(posedge clk) disable iff (rst)
        !chop_en |=> (out_a == $past(pwm_a)));
    a_r1_bypass_b: assert property (@(posedge clk) disable iff (rst)
        !chop_en |=> (out_b == $past(pwm_b)));

    a_r3_shot_start_a: assert property (@(posedge clk) disable iff (rst)
        (chop_en && pwm_a && !$past(pwm_a)) |=> out_a);
    a_r3_shot_start_b: assert property (@(posedge clk) disable iff (rst)
        (chop_en && pwm_b && !$past(pwm_b)) |=> out_b);

    a_r7_fall_ends_a: assert property (@(posedge clk) disable iff (rst)
        !pwm_a |=> (!os_a || pwm_a));
    a_r7_fall_ends_b: assert property (@(posedge clk) disable iff (rst)
        !pwm_b |=> (!os_b || pwm_b));

endmodule

bind pwm_chopper pwm_chopper_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .chop_en (chop_en),
    .pwm_a   (pwm_a),
    .pwm_b   (pwm_b),
    .out_a   (out_a),
    .out_b   (out_b),
    .os_a    (shot[0]),
    .os_b    (shot[1])
);

// File: tb/pwm_chopper_test.sv
`timescale 1ns/1ps
module pwm_chopper_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       chop_en = 1'b0;
    logic [2:0] car_freq = '0;
    logic [2:0] car_duty = '0;
    logic [3:0] os_width = '0;
    logic       pwm_a = 1'b0;
    logic       pwm_b = 1'b0;
    logic       out_a, out_b;

    int         checks = 0;
    int         fails  = 0;
    int         t      = 0;
    int         rem_m[2];
    logic [1:0] prev_m = '0;
    logic [1:0] exp_out = '0;
    bit         exp_ok = 0;
    bit         done = 0;

    always #4 clk = ~clk;

    pwm_chopper uut (
        .clk(clk), .rst(rst), .chop_en(chop_en), .car_freq(car_freq),
        .car_duty(car_duty), .os_width(os_width), .pwm_a(pwm_a),
        .pwm_b(pwm_b), .out_a(out_a), .out_b(out_b)
    );

    // Carrier level in phase k, from R4/R5/R6.
    function automatic logic carrier_at(int k, int f, int d);
        int de = (d == 7) ? 3 : d;
        return ((k / (f + 1)) % 8) <= de;
    endfunction

    task automatic check(string tag, int ch, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s ch%0d t=%0d actual=%b expected=%b", tag, ch, t, act, exp);
        end
    endtask

    // Called just after a falling edge: check, drive interval t, predict t+1.
    task automatic apply(logic [1:0] p, string tag);
        logic car;
        if (exp_ok) begin
            check(tag, 0, out_a, exp_out[0]);
            check(tag, 1, out_b, exp_out[1]);
        end
        pwm_a = p[0];
        pwm_b = p[1];
        car = carrier_at(t, int'(car_freq), int'(car_duty));
        for (int ch = 0; ch < 2; ch++) begin
            logic rise, os;
            rise = p[ch] & ~prev_m[ch];
            os   = rise | (rem_m[ch] > 0);
            exp_out[ch] = chop_en ? (p[ch] & (os | car)) : p[ch];
            if (!p[ch])     rem_m[ch] = 0;
            else if (rise)  rem_m[ch] = 8 * (int'(os_width) + 1) - 1;
            else if (rem_m[ch] > 0) rem_m[ch]--;
            prev_m[ch] = p[ch];
        end
        exp_ok = 1;
        t++;
    endtask

    task automatic cycle(logic [1:0] p, string tag);
        @(negedge clk);
        apply(p, tag);
    endtask

    task automatic hold(logic [1:0] p, int n, string tag);
        repeat (n) cycle(p, tag);
    endtask

    task automatic restart(bit en, int f, int d, int w);
        @(negedge clk);
        rst = 1'b1;
        exp_ok = 0;
        chop_en  = en;
        car_freq = 3'(f);
        car_duty = 3'(d);
        os_width = 4'(w);
        pwm_a = 1'b0;
        pwm_b = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R9", 0, out_a, 1'b0);
        check("R9", 1, out_b, 1'b0);
        rst = 1'b0;
        t = 0;
        prev_m = '0;
        rem_m[0] = 0;
        rem_m[1] = 0;
        apply(2'b00, "R9");
    endtask

    task automatic run_random(string tag, int n, int maxhold);
        int hl[2];
        logic [1:0] lv;
        hl[0] = 0;
        hl[1] = 0;
        lv = '0;
        for (int i = 0; i < n; i++) begin
            for (int ch = 0; ch < 2; ch++) begin
                if (hl[ch] == 0) begin
                    lv[ch] = 1'($urandom_range(0, 1));
                    hl[ch] = $urandom_range(1, maxhold);
                end else begin
                    hl[ch]--;
                end
            end
            cycle(lv, tag);
        end
    endtask

    initial begin
        void'($urandom(32'd2024));

        // R1: bypass pass-through
        restart(0, 3, 2, 5);
        run_random("R1", 300, 12);

        // R3: one-shot width 24 with a sparse carrier
        restart(1, 7, 0, 2);
        hold(2'b00, 10, "R3");
        hold(2'b01, 60, "R3");
        hold(2'b00, 6, "R3");
        hold(2'b10, 40, "R3");

        // R7: falling edge truncates a long one-shot, then a full restart
        restart(1, 6, 1, 15);
        hold(2'b00, 5, "R7");
        hold(2'b11, 30, "R7");
        hold(2'b00, 3, "R7");
        hold(2'b11, 140, "R7");
        hold(2'b00, 5, "R7");

        // R5: random frequency, duty 0..6 and width
        for (int s = 0; s < 4; s++) begin
            restart(1, $urandom_range(0, 7), $urandom_range(0, 6), $urandom_range(0, 15));
            run_random("R5", 400, 60);
        end

        // R6: reserved duty code
        restart(1, 3, 7, 1);
        run_random("R6", 400, 80);

        // R4: period extremes
        restart(1, 0, 2, 0);
        hold(2'b11, 200, "R4");
        restart(1, 7, 5, 0);
        hold(2'b11, 300, "R4");

        // R8: channel A held high while B toggles
        restart(1, 2, 3, 4);
        for (int i = 0; i < 300; i++)
            cycle({1'($urandom_range(0, 1)), 1'b1}, "R8");

        // R2: short bursts, output must track low input
        restart(1, $urandom_range(0, 7), $urandom_range(0, 7), $urandom_range(0, 15));
        run_random("R2", 400, 4);

        @(negedge clk);
        check("R2", 0, out_a, exp_out[0]);
        check("R2", 1, out_b, exp_out[1]);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired t=%0d actual=hung expected=done", t);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule